// File: doc/BRIEF.md
# Structured-Sparse Chunk Dot-Product Unit

This unit accumulates the dot product of a compressed, structurally sparse row of operand A with a dense column of operand B. Operand A arrives packed. Only the kept (non-zero) elements are present. Each kept element carries a 2-bit position code that says which column it came from inside its 4-wide sub-chunk, and every sub-chunk keeps exactly two elements. For each kept element the unit uses its position code to pick the matching B element, forms the product, and adds it into a 32-bit running sum. Zeros are never stored or multiplied.

Each accepted beat carries one 32-bit packed A word, the position codes for that word and a 64-bit dense B chunk. The element width is chosen per beat. In 16-bit mode two kept values span 4 columns. In 8-bit mode four kept values span 8 columns. In 4-bit mode eight kept values span 16 columns. A signedness input picks two's-complement or unsigned reading for A and B together. A 32-bit metadata word holds the codes for two 4-bit beats, so the feeder presents one 16-bit half of it per beat.

A clear input restarts the sum. A last flag marks the final beat of a dot product, and a one-cycle done pulse then shows the finished sum. A pair of position codes that is not strictly increasing is treated as malformed: that pair adds nothing and an error flag marks the beat.

Top module: `sparse_dot_unit`

## Requirements
- R1: While `rstN` is low, `accOut` is 0, `done` and `errFlag` are 0 and `inReady` is 0. From the first clock edge after reset is released, `inReady` is 1.
- R2: With `elemMode`=0 (16-bit), kept element e (e=0,1) is `aWord[16e+15:16e]` and uses position field e. Field k is `metaBits[2k+1:2k]`. The selected B element p is `bChunk[16p+15:16p]`.
- R3: With `elemMode`=1 (8-bit), kept element e (e=0..3) is `aWord[8e+7:8e]`. It belongs to sub-chunk e/2 and selects B element index 4*(e/2)+field e, where B element i is `bChunk[8i+7:8i]`.
- R4: With `elemMode`=2 or 3 (4-bit), kept element e (e=0..7) is `aWord[4e+3:4e]`. It selects B element index 4*(e/2)+field e, where B element i is `bChunk[4i+3:4i]`.
- R5: With `isSigned`=1, both A and B elements are sign-extended. With `isSigned`=0, both are zero-extended. Products and the sum wrap modulo 2^32.
- R6: Each beat accepted (`inValid` and `inReady` high at a clock edge) adds its beat sum to the accumulator. Cycles with `inValid` low leave `accOut` unchanged whatever the data inputs hold.
- R7: A pair whose first field (even k) is greater than or equal to its second field (k+1) contributes nothing, while the other pairs of the beat still add. `errFlag` is 1 for exactly the cycle after such a beat.
- R8: `done` is 1 for one cycle, the cycle after a beat accepted with `inLast`=1, and in that cycle `accOut` already includes that beat.
- R9: `clear` alone zeroes `accOut` from the next cycle. `clear` together with an accepted beat makes `accOut` equal to that beat's sum alone.
- R10: Position fields beyond those the mode uses (fields 2..7 in 16-bit mode, fields 4..7 in 8-bit mode) have no effect on the sum or on `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart the running sum |
| inValid | input | 1 | Beat present on the data inputs |
| inReady | output | 1 | Unit accepts a beat this cycle |
| inLast | input | 1 | Beat is the final one of a dot product |
| elemMode | input | 2 | 0: 16-bit, 1: 8-bit, 2 or 3: 4-bit elements |
| isSigned | input | 1 | Two's-complement reading of A and B |
| aWord | input | 32 | Packed kept A elements |
| metaBits | input | 16 | Eight 2-bit position fields for this beat |
| bChunk | input | 64 | Dense B elements covering the beat's columns |
| accOut | output | 32 | Running sum |
| done | output | 1 | One-cycle pulse after the last beat |
| errFlag | output | 1 | Previous beat held a malformed pair |

## Verification
The clear-restart and beat-accumulate functions can both hit the accumulator in the same cycle. The bench forces this by asserting `clear` together with a valid beat while the sum is already nonzero. The result passes only if `accOut` equals the new beat alone, and neither the old total nor zero is accepted. The same collision appears in the vector table, where every row clears and ends in one beat, so both `done` and the fresh sum are judged in the cycle after.

// File: rtl/sparse_dot_pkg.sv
`timescale 1ns/1ps
package sparse_dot_pkg;

  localparam int WORD_W     = 32;           // packed A word
  localparam int CHUNK_W    = 2 * WORD_W;   // dense B span per beat
  localparam int META_W     = WORD_W / 2;   // widest per-beat code set
  localparam int ACC_W      = 32;
  localparam int LANE_MODES = 3;            // 16-, 8-, 4-bit element lanes

  typedef enum logic [1:0] {
    ELEM16  = 2'd0,
    ELEM8   = 2'd1,
    ELEM4   = 2'd2,
    ELEM4B  = 2'd3
  } elemMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBeat;
    logic zeroAcc;
  } ctrlStrobe_t;

endpackage

// File: rtl/sparse_dot_lanes.sv
`timescale 1ns/1ps
// One element-width variant: gathers B by position code, multiplies, sums.
module sparse_dot_lanes #(
  parameter int ELEM_W  = 16,
  parameter int KEPT    = 2,
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 64,
  parameter int ACC_W   = 32
) (
  input  logic [WORD_W-1:0]   aWord,
  input  logic [2*KEPT-1:0]   metaCodes,
  input  logic [CHUNK_W-1:0]  bChunk,
  input  logic                isSigned,
  output logic [ACC_W-1:0]    laneSum,
  output logic [KEPT/2-1:0]   pairBad
);

  localparam int PAIRS   = KEPT / 2;
  localparam int SUB_W   = 4 * ELEM_W;     // one 4-wide sub-chunk of B

  logic [ACC_W-1:0] prodArr [KEPT];

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign pairBad[j] = metaCodes[4*j +: 2] >= metaCodes[4*j+2 +: 2];
  end

  for (genvar e = 0; e < KEPT; e++) begin : g_elem
    localparam int SUB = e / 2;
    logic [1:0]        posCode;
    logic [SUB_W-1:0]  subChunk;
    logic [ELEM_W-1:0] aElem;
    logic [ELEM_W-1:0] bElem;
    logic [ACC_W-1:0]  aExt;
    logic [ACC_W-1:0]  bExt;

    assign posCode  = metaCodes[2*e +: 2];
    assign subChunk = bChunk[SUB*SUB_W +: SUB_W];
    assign aElem    = aWord[e*ELEM_W +: ELEM_W];
    assign bElem    = subChunk[posCode*ELEM_W +: ELEM_W];
    assign aExt     = {{(ACC_W-ELEM_W){isSigned & aElem[ELEM_W-1]}}, aElem};
    assign bExt     = {{(ACC_W-ELEM_W){isSigned & bElem[ELEM_W-1]}}, bElem};
    assign prodArr[e] = aExt * bExt;
  end

  always_comb begin
    laneSum = '0;
    for (int e = 0; e < KEPT; e++) begin
      if (!pairBad[e/2]) laneSum = laneSum + prodArr[e];
    end
  end

  // R7
  always_comb begin
    if (&pairBad) begin
      bad_pair_zero_chk: assert (laneSum == '0);
    end
  end

endmodule

// File: rtl/sparse_dot_ctrl.sv
`timescale 1ns/1ps
module sparse_dot_ctrl
  import sparse_dot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output ctrlStrobe_t strobes,
  output logic        done
);

  logic readyQ;
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      doneQ  <= inValid && readyQ && inLast;
    end
  end

  assign inReady          = readyQ;
  assign strobes.takeBeat = inValid && readyQ;
  assign strobes.zeroAcc  = clear;
  assign done             = doneQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !(inValid && inLast)) |=> !doneQ);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ);

endmodule

// File: rtl/sparse_dot_datapath.sv
`timescale 1ns/1ps
module sparse_dot_datapath
  import sparse_dot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobes,
  input  logic [1:0]         elemMode,
  input  logic               isSigned,
  input  logic [WORD_W-1:0]  aWord,
  input  logic [META_W-1:0]  metaBits,
  input  logic [CHUNK_W-1:0] bChunk,
  output logic [ACC_W-1:0]   accOut,
  output logic               errFlag
);

  logic [ACC_W-1:0] laneSum [LANE_MODES];
  logic             laneBad [LANE_MODES];
  logic [ACC_W-1:0] beatSum;
  logic             beatBad;
  logic [ACC_W-1:0] accQ;
  logic             errQ;

  for (genvar g = 0; g < LANE_MODES; g++) begin : g_lane
    localparam int EW = (WORD_W / 2) >> g;
    localparam int KP = 2 << g;
    logic [KP/2-1:0] pairBad;

    sparse_dot_lanes #(
      .ELEM_W (EW),
      .KEPT   (KP),
      .WORD_W (WORD_W),
      .CHUNK_W(CHUNK_W),
      .ACC_W  (ACC_W)
    ) i_lanes (
      .aWord    (aWord),
      .metaCodes(metaBits[2*KP-1:0]),
      .bChunk   (bChunk),
      .isSigned (isSigned),
      .laneSum  (laneSum[g]),
      .pairBad  (pairBad)
    );

    assign laneBad[g] = |pairBad;
  end

  always_comb begin
    case (elemMode)
      ELEM16:  begin beatSum = laneSum[0]; beatBad = laneBad[0]; end
      ELEM8:   begin beatSum = laneSum[1]; beatBad = laneBad[1]; end
      default: begin beatSum = laneSum[2]; beatBad = laneBad[2]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (strobes.takeBeat)
        accQ <= (strobes.zeroAcc ? '0 : accQ) + beatSum;
      else if (strobes.zeroAcc)
        accQ <= '0;
      errQ <= strobes.takeBeat && beatBad;
    end
  end

  assign accOut  = accQ;
  assign errFlag = errQ;

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.takeBeat && !strobes.zeroAcc) |=> $stable(accQ));

  // R9
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.zeroAcc && !strobes.takeBeat) |=> (accQ == '0));

  // R7
  err_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeBeat |=> !errQ);

endmodule

// File: rtl/sparse_dot_unit.sv
`timescale 1ns/1ps
module sparse_dot_unit
  import sparse_dot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inLast,
  input  logic [1:0]         elemMode,
  input  logic               isSigned,
  input  logic [WORD_W-1:0]  aWord,
  input  logic [META_W-1:0]  metaBits,
  input  logic [CHUNK_W-1:0] bChunk,
  output logic [ACC_W-1:0]   accOut,
  output logic               done,
  output logic               errFlag
);

  ctrlStrobe_t strobes;

  sparse_dot_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (clear),
    .inValid(inValid),
    .inLast (inLast),
    .inReady(inReady),
    .strobes(strobes),
    .done   (done)
  );

  sparse_dot_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .elemMode(elemMode),
    .isSigned(isSigned),
    .aWord   (aWord),
    .metaBits(metaBits),
    .bChunk  (bChunk),
    .accOut  (accOut),
    .errFlag (errFlag)
  );

endmodule

// File: tb/test_sparse_dot_unit.sv
`timescale 1ns/1ps
module test_sparse_dot_unit;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic [31:0] a;
    logic [15:0] meta;
    logic [63:0] b;
    logic [31:0] sum;
    logic        err;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC_TABLE [NVEC] = '{
    // 0 R2: 2*b1 + 3*b3 = 40 + 120
    '{2'd0, 1'b0, 32'h0003_0002, 16'h000D, 64'h0028_001E_0014_000A, 32'd160, 1'b0},
    // 1 R5 R10: signed, junk in unused fields; (-2)(-3) + 5*4
    '{2'd0, 1'b1, 32'h0005_FFFE, 16'hFFF8, 64'h0064_0004_0007_FFFD, 32'd26, 1'b0},
    // 2 R5: same operands unsigned, wraps
    '{2'd0, 1'b0, 32'h0005_FFFE, 16'h0008, 64'h0064_0004_0007_FFFD, 32'hFFFB_001A, 1'b0},
    // 3 R3 R10: 1*10 + 2*13 + 3*15 + 4*16
    '{2'd1, 1'b0, 32'h0403_0201, 16'hAB9C, 64'h1110_0F0E_0D0C_0B0A, 32'd145, 1'b0},
    // 4 R3 R5: signed bytes
    '{2'd1, 1'b1, 32'h04FD_02FF, 16'h00C9, 64'h0A01_01F7_0807_FA05, 32'd87, 1'b0},
    // 5 R4: nibble lanes, B element i equals i
    '{2'd2, 1'b0, 32'h8765_4321, 16'h9CE4, 64'hFEDC_BA98_7654_3210, 32'd357, 1'b0},
    // 6 R4 R5: mode 3, signed nibbles
    '{2'd3, 1'b1, 32'h8765_4321, 16'h9CE4, 64'hFEDC_BA98_7654_3210, 32'hFFFF_FFE5, 1'b0},
    // 7 R7: equal codes in 16-bit pair
    '{2'd0, 1'b0, 32'h0003_0002, 16'h000A, 64'h0028_001E_0014_000A, 32'd0, 1'b1},
    // 8 R7: second 8-bit pair decreasing, first pair still adds
    '{2'd1, 1'b0, 32'h0403_0201, 16'h006C, 64'h1110_0F0E_0D0C_0B0A, 32'd36, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        clear;
  logic        inValid;
  logic        inReady;
  logic        inLast;
  logic [1:0]  elemMode;
  logic        isSigned;
  logic [31:0] aWord;
  logic [15:0] metaBits;
  logic [63:0] bChunk;
  logic [31:0] accOut;
  logic        done;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sparse_dot_unit i_sparse_dot_unit (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .inValid (inValid),
    .inReady (inReady),
    .inLast  (inLast),
    .elemMode(elemMode),
    .isSigned(isSigned),
    .aWord   (aWord),
    .metaBits(metaBits),
    .bChunk  (bChunk),
    .accOut  (accOut),
    .done    (done),
    .errFlag (errFlag)
  );

  function automatic string vecReq(input int i);
    case (i)
      0: return "R2";
      1: return "R5 R10";
      2: return "R5";
      3: return "R3 R10";
      4: return "R3";
      5: return "R4";
      6: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one beat before an edge, return at the following falling edge
  task automatic sendBeat(input vec_t v, input logic clr, input logic last);
    elemMode = v.mode;
    isSigned = v.sgn;
    aWord    = v.a;
    metaBits = v.meta;
    bChunk   = v.b;
    inValid  = 1'b1;
    clear    = clr;
    inLast   = last;
    @(negedge clk);
    inValid  = 1'b0;
    clear    = 1'b0;
    inLast   = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; clear = 1'b0; inValid = 1'b0; inLast = 1'b0;
    elemMode = 2'd0; isSigned = 1'b0; aWord = '0; metaBits = '0; bChunk = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 inReady in reset", {31'd0, inReady}, 32'd0);
    check("R1 accOut in reset", accOut, 32'd0);
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 errFlag in reset", {31'd0, errFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inReady after reset", {31'd0, inReady}, 32'd1);

    // vector table: each row clears, is a single last beat
    for (int i = 0; i < NVEC; i++) begin
      sendBeat(VEC_TABLE[i], 1'b1, 1'b1);
      check($sformatf("%s vector %0d sum", vecReq(i), i), accOut, VEC_TABLE[i].sum);
      check($sformatf("R8 vector %0d done", i), {31'd0, done}, 32'd1);
      check($sformatf("%s vector %0d errFlag", vecReq(i), i), {31'd0, errFlag},
            {31'd0, VEC_TABLE[i].err});
    end

    // R6 multi-beat accumulate with an idle cycle carrying junk
    sendBeat(VEC_TABLE[0], 1'b1, 1'b0);
    check("R6 first beat sum", accOut, 32'd160);
    check("R8 no done before last", {31'd0, done}, 32'd0);
    aWord = 32'hFFFF_FFFF; metaBits = 16'h4E4E; bChunk = '1; elemMode = 2'd2;
    @(negedge clk);
    check("R6 idle cycle holds sum", accOut, 32'd160);
    sendBeat(VEC_TABLE[3], 1'b0, 1'b1);
    check("R6 two-beat sum", accOut, 32'd305);
    check("R8 done after last", {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R8 done single cycle", {31'd0, done}, 32'd0);
    check("R8 sum kept after done", accOut, 32'd305);

    // R9 clear in the same cycle as a beat, on a nonzero sum
    sendBeat(VEC_TABLE[0], 1'b1, 1'b1);
    check("R9 clear with beat", accOut, 32'd160);

    // R9 clear alone
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R9 clear alone", accOut, 32'd0);

    // R7 error flag lasts one cycle
    sendBeat(VEC_TABLE[8], 1'b1, 1'b0);
    check("R7 partial sum with bad pair", accOut, 32'd36);
    check("R7 errFlag set", {31'd0, errFlag}, 32'd1);
    @(negedge clk);
    check("R7 errFlag single cycle", {31'd0, errFlag}, 32'd0);

    // R5 wrap across two beats
    sendBeat(VEC_TABLE[2], 1'b1, 1'b0);
    sendBeat(VEC_TABLE[2], 1'b0, 1'b1);
    check("R5 accumulated wrap", accOut, 32'hFFF6_0034);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule